// File: doc/BRIEF.md
# Wide System Timer with Coherent Capture

This block keeps a 56-bit time base for a whole chip. The count only goes up and wraps with no stop. It advances once per enable pulse from an integer prescaler, and a 3-bit divide field sets the spacing of those pulses. Software cannot write the count. It sees the count only through 32-bit read windows on a simple register bus, and every read returns data one cycle after the request.

Each window shows a different 32-bit slice of the count. A read of any of the six sliding windows also copies count bits 55:32 into a holding register on the same edge that samples the slice. A second read of that holding register then gives the upper part that belongs with the first read, even if a carry into bit 32 happens between the two reads.

The count has several reset inputs, one for each reset cause. Power-on and watchdog resets always clear it. A software reset clears it only while the timer-reset request input is high. An external hardware reset leaves both the count and the divide field untouched. A debug suspend input freezes the count, and all registers stay readable while it is high. The parameter `RST_VAL` gives the value loaded on a clear, and its default is zero.

Top module: `wide_sys_timer`

## Requirements
- R1: While `por_rst` or `wdt_rst` is high, the count loads `RST_VAL` and the divide field loads 2. After release, counting resumes with no further action, at one step every 2 cycles.
- R2: With a divide value D from 1 to 7, the count rises by exactly 1 every D cycles. Over any span of k·D cycles it therefore rises by k.
- R3: A divide value of 0 stops the enable pulses, and the count holds its value.
- R4: A write to address 8 stores `wdata[2:0]` as the divide field. Reading address 8 returns that field in bits 2:0 with zeros above it. The new value takes over the count rate at the next prescaler rollover.
- R5: A read at address k, for k from 0 to 5, returns count bits [4k+31:4k]. Address 6 returns count bits 55:32 zero-extended to 32 bits. Read data appears on `rdata` one cycle after `rd_en`.
- R6: A read at addresses 0 to 5 stores count bits 55:32 in the capture register on the same edge that samples the window. Address 7 returns the capture register zero-extended. No other read changes the capture register.
- R7: Writes to any address other than 8 have no effect on the count, the divide field or the capture register.
- R8: While `dbg_suspend` is high, the count and the prescaler hold their values, and all addresses remain readable.
- R9: A software reset with `sw_tmr_req` high acts as in R1. With `sw_tmr_req` low, it leaves the count and the divide field unchanged.
- R10: `hw_rst` clears only `rdata`. The count keeps running and the divide field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| sw_tmr_req | input | 1 | Lets a software reset clear the timer |
| hw_rst | input | 1 | External hardware reset; clears only the read data register |
| dbg_suspend | input | 1 | Freezes counting while high |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |

## Verification
The assertions assume that the reset inputs are synchronous levels that are never X after time zero. They also assume that `rd_en`, `wr_en` and `addr` are settled before each rising edge, and that the bus never issues a read and a write to the divide register in the same cycle. The bench changes every input on the falling clock edge and issues at most one bus request per cycle. It starts with power-on reset high at time zero, so every clocked property begins from a cleared state. The bench sets `RST_VAL` a few hundred counts below a carry into bit 32, so the upper bits change during the run and the capture path is exercised across a real carry.

// File: rtl/wst_pkg.sv
package wst_pkg;

    localparam int CNT_W    = 56;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int WIN_CNT  = 6;
    localparam int WIN_STEP = 4;
    localparam int HI_W     = CNT_W - DATA_W;
    localparam int DIV_W    = 3;

    localparam logic [DIV_W-1:0]  DIV_RST = DIV_W'(2);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } bus_req_t;

    typedef enum logic [2:0] {
        SEL_WIN,
        SEL_HI,
        SEL_CAP,
        SEL_CTRL,
        SEL_NONE
    } sel_e;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        if (a < ADDR_W'(WIN_CNT)) return SEL_WIN;
        if (a == A_HI)            return SEL_HI;
        if (a == A_CAP)           return SEL_CAP;
        if (a == A_CTRL)          return SEL_CTRL;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler
    import wst_pkg::*;
(
    input  logic clk,
    input  logic clr_i,
    input  logic suspend_i,
    input  div_t div_cfg_i,
    output logic tick_o,
    output div_t div_act_o
);

    div_t pre_q;
    div_t div_act_q;
    logic roll;

    assign roll      = (div_act_q != '0) && (pre_q == div_act_q - DIV_W'(1));
    assign tick_o    = roll && !suspend_i;
    assign div_act_o = div_act_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            pre_q     <= '0;
            div_act_q <= DIV_RST;
        end else if (!suspend_i) begin
            if (div_act_q == '0) begin
                pre_q     <= '0;
                div_act_q <= div_cfg_i;
            end else if (roll) begin
                pre_q     <= '0;
                div_act_q <= div_cfg_i;
            end else begin
                pre_q     <= pre_q + DIV_W'(1);
            end
        end
    end

    // R4
    div_act_hold_chk: assert property (@(posedge clk) disable iff (clr_i)
        (!tick_o && div_act_q != '0) |=> $stable(div_act_q));

endmodule

// File: rtl/wst_counter.sv
module wst_counter
    import wst_pkg::*;
#(
    parameter cnt_t RST_VAL = '0
) (
    input  logic clk,
    input  logic clr_i,
    input  logic tick_i,
    output cnt_t cnt_o
);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (clr_i)
            cnt_q <= RST_VAL;
        else if (tick_i)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wst_regif.sv
module wst_regif
    import wst_pkg::*;
(
    input  logic     clk,
    input  logic     clr_i,
    input  logic     hw_rst_i,
    input  bus_req_t req_i,
    input  cnt_t     cnt_i,
    output div_t     div_o,
    output word_t    rdata_o
);

    word_t win_w [WIN_CNT];
    div_t  div_q;
    hi_t   cap_q;
    word_t rdata_q;
    word_t rd_val;
    sel_e  sel;
    logic  win_rd;
    logic  ctrl_wr;
    logic  unused_wdata;

    for (genvar g = 0; g < WIN_CNT; g++) begin : g_win
        assign win_w[g] = cnt_i[g*WIN_STEP +: DATA_W];
    end

    assign sel          = decode(req_i.addr);
    assign win_rd       = req_i.rd && (sel == SEL_WIN);
    assign ctrl_wr      = req_i.wr && (sel == SEL_CTRL);
    assign unused_wdata = ^req_i.wdata[DATA_W-1:DIV_W];

    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_WIN: begin
                for (int i = 0; i < WIN_CNT; i++)
                    if (req_i.addr == ADDR_W'(i)) rd_val = win_w[i];
            end
            SEL_HI:   rd_val = DATA_W'(cnt_i[CNT_W-1:DATA_W]);
            SEL_CAP:  rd_val = DATA_W'(cap_q);
            SEL_CTRL: rd_val = DATA_W'(div_q);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr_i) begin
            div_q <= DIV_RST;
            cap_q <= '0;
        end else begin
            if (ctrl_wr) div_q <= req_i.wdata[DIV_W-1:0];
            if (win_rd)  cap_q <= cnt_i[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (clr_i || hw_rst_i)
            rdata_q <= '0;
        else if (req_i.rd)
            rdata_q <= rd_val;
    end

    assign div_o   = div_q;
    assign rdata_o = rdata_q;

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (clr_i)
        !win_rd |=> $stable(cap_q));

    // R7
    div_write_guard_chk: assert property (@(posedge clk) disable iff (clr_i)
        !(req_i.wr && req_i.addr == A_CTRL) |=> $stable(div_q));

endmodule

// File: rtl/wide_sys_timer.sv
module wide_sys_timer
    import wst_pkg::*;
#(
    parameter logic [55:0] RST_VAL = '0
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        wdt_rst,
    input  logic        sw_rst,
    input  logic        sw_tmr_req,
    input  logic        hw_rst,
    input  logic        dbg_suspend,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    logic     full_clr;
    logic     tick;
    div_t     div_cfg;
    div_t     div_act;
    cnt_t     cnt;
    bus_req_t req;

    assign full_clr = por_rst || wdt_rst || (sw_rst && sw_tmr_req);
    assign req      = '{rd: rd_en, wr: wr_en, addr: addr, wdata: wdata};

    wst_prescaler u_pre (
        .clk       (clk),
        .clr_i     (full_clr),
        .suspend_i (dbg_suspend),
        .div_cfg_i (div_cfg),
        .tick_o    (tick),
        .div_act_o (div_act)
    );

    wst_counter #(.RST_VAL(RST_VAL)) u_cnt (
        .clk    (clk),
        .clr_i  (full_clr),
        .tick_i (tick),
        .cnt_o  (cnt)
    );

    wst_regif u_reg (
        .clk      (clk),
        .clr_i    (full_clr),
        .hw_rst_i (hw_rst),
        .req_i    (req),
        .cnt_i    (cnt),
        .div_o    (div_cfg),
        .rdata_o  (rdata)
    );

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (full_clr)
        tick |=> cnt == $past(cnt) + CNT_W'(1));

    // R3
    zero_div_hold_chk: assert property (@(posedge clk) disable iff (full_clr)
        (div_act == '0) |=> $stable(cnt));

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (full_clr)
        dbg_suspend |=> $stable(cnt) && $stable(div_act));

    // R9
    sw_noreq_chk: assert property (@(posedge clk) disable iff (full_clr)
        (sw_rst && !sw_tmr_req) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    // R10
    hw_keep_chk: assert property (@(posedge clk) disable iff (full_clr)
        hw_rst |=> $stable(div_cfg) && (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: tb/tb_wide_sys_timer.sv
module tb_wide_sys_timer;

    localparam logic [55:0] RV    = 56'h12_3456_FFFF_FF00;
    localparam logic [31:0] RV_LO = RV[31:0];
    localparam logic [23:0] RV_HI = RV[55:32];
    localparam int NVEC = 6;
    // stimulus: divide value, gap in cycles; expected count delta
    localparam int VEC_DIV [NVEC] = '{1, 3, 7, 0, 5, 2};
    localparam int VEC_GAP [NVEC] = '{20, 30, 42, 30, 40, 24};
    localparam int VEC_EXP [NVEC] = '{20, 10, 6, 0, 8, 12};

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        wdt_rst = 1'b0;
    logic        sw_rst = 1'b0;
    logic        sw_tmr_req = 1'b0;
    logic        hw_rst = 1'b0;
    logic        dbg_suspend = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wide_sys_timer #(.RST_VAL(RV)) dut (
        .clk(clk), .por_rst(por_rst), .wdt_rst(wdt_rst), .sw_rst(sw_rst),
        .sw_tmr_req(sw_tmr_req), .hw_rst(hw_rst), .dbg_suspend(dbg_suspend),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v1, v2, c, a6, w [6];
        logic [55:0] full, prev;
        idle(3);
        por_rst = 1'b0;

        // R1 reset state and automatic start
        bus_rd(4'd8, v1); check(v1 == 32'd2, "R1 div after por", v1, 2);
        bus_rd(4'd6, v1); check(v1 == {8'h0, RV_HI}, "R1 hi after por", v1, RV_HI);
        bus_rd(4'd0, v1); check((v1 - RV_LO) <= 32'd3, "R1 lo after por", v1, RV_LO);

        // R6 coherent pair across the carry into bit 32, divide 1
        bus_wr(4'd8, 32'd1);
        idle(10);
        prev = '0;
        for (int i = 0; i < 200; i++) begin
            bus_rd(4'd0, v1);
            bus_rd(4'd7, c);
            full = {c[23:0], v1};
            if (i > 0 && full - prev != 56'd2) begin
                check(1'b0, "R6 coherent pair step", full - prev, 2);
            end
            prev = full;
        end
        check(c == {8'h0, RV_HI + 24'd1}, "R6 capture after carry", c, RV_HI + 24'd1);

        // R5 windows and R8 suspend
        dbg_suspend = 1'b1;
        idle(2);
        for (int k = 0; k < 6; k++) bus_rd(4'(k), w[k]);
        bus_rd(4'd6, a6);
        check(a6[31:24] == 8'h0, "R5 hi window zero-extended", a6, a6[23:0]);
        full = {a6[23:0], w[0]};
        for (int k = 1; k < 6; k++)
            check(w[k] == full[k*4 +: 32], "R5 window slice", w[k], full[k*4 +: 32]);
        bus_rd(4'd7, c);
        check(c == a6, "R6 capture equals hi", c, a6);
        idle(40);
        bus_rd(4'd0, v1);
        check(v1 == w[0], "R8 count frozen", v1, w[0]);
        bus_rd(4'd7, c);
        check(c == a6, "R8 capture kept", c, a6);
        dbg_suspend = 1'b0;

        // R7 writes elsewhere ignored (divide still 1)
        idle(5);
        bus_rd(4'd0, v1);
        bus_wr(4'd0, 32'hFFFF_FFFF);
        bus_wr(4'd7, 32'h0);
        bus_wr(4'd6, 32'h0);
        bus_rd(4'd0, v2);
        check(v2 - v1 == 32'd4, "R7 count unaffected", v2 - v1, 4);
        bus_rd(4'd8, v1); check(v1 == 32'd1, "R7 div unaffected", v1, 1);
        bus_rd(4'd7, c);  check(c == a6, "R7 capture unaffected", c, a6);

        // R4 field masking
        bus_wr(4'd8, 32'hFFFF_FFF3);
        bus_rd(4'd8, v1); check(v1 == 32'd3, "R4 div readback", v1, 3);

        // R2 R3 R4 rate table
        for (int i = 0; i < NVEC; i++) begin
            bus_wr(4'd8, 32'(VEC_DIV[i]));
            idle(20);
            bus_rd(4'd8, v1);
            check(v1 == 32'(VEC_DIV[i]), "R4 div value", v1, VEC_DIV[i]);
            bus_rd(4'd0, v1);
            idle(VEC_GAP[i] - 1);
            bus_rd(4'd0, v2);
            check(v2 - v1 == 32'(VEC_EXP[i]), VEC_DIV[i] == 0 ? "R3 zero div hold" : "R2 rate",
                  v2 - v1, VEC_EXP[i]);
        end

        // R9 software reset without and with request
        bus_wr(4'd8, 32'd4);
        idle(10);
        bus_rd(4'd0, v1);
        sw_rst = 1'b1; idle(2); sw_rst = 1'b0;
        bus_rd(4'd8, v2); check(v2 == 32'd4, "R9 no-req div kept", v2, 4);
        bus_rd(4'd0, v2); check(v2 - v1 <= 32'd3, "R9 no-req count kept", v2 - v1, 2);
        sw_tmr_req = 1'b1; sw_rst = 1'b1; idle(2); sw_rst = 1'b0; sw_tmr_req = 1'b0;
        bus_rd(4'd8, v2); check(v2 == 32'd2, "R9 req div cleared", v2, 2);
        bus_rd(4'd6, v2); check(v2 == {8'h0, RV_HI}, "R9 req hi cleared", v2, RV_HI);
        bus_rd(4'd0, v2); check(v2 - RV_LO <= 32'd3, "R9 req lo cleared", v2, RV_LO);

        // R10 hardware reset keeps timer
        bus_wr(4'd8, 32'd5);
        idle(12);
        bus_rd(4'd0, v1);
        hw_rst = 1'b1; idle(1);
        check(rdata == 32'h0, "R10 rdata cleared", rdata, 0);
        idle(2); hw_rst = 1'b0;
        bus_rd(4'd8, v2); check(v2 == 32'd5, "R10 div kept", v2, 5);
        bus_rd(4'd0, v2); check(v2 - v1 <= 32'd3, "R10 count kept", v2 - v1, 1);

        // R1 watchdog reset
        bus_wr(4'd8, 32'd1);
        idle(300);
        bus_rd(4'd6, v1); check(v1 == {8'h0, RV_HI + 24'd1}, "R1 hi before wdt", v1, RV_HI + 24'd1);
        wdt_rst = 1'b1; idle(2); wdt_rst = 1'b0;
        bus_rd(4'd6, v1); check(v1 == {8'h0, RV_HI}, "R1 hi after wdt", v1, RV_HI);
        bus_rd(4'd8, v1); check(v1 == 32'd2, "R1 div after wdt", v1, 2);
        bus_rd(4'd0, v1);
        idle(9);
        bus_rd(4'd0, v2);
        check(v2 - v1 == 32'd5, "R1 resumes at half rate", v2 - v1, 5);

        report();
    end

endmodule